// File: doc/BRIEF.md
# Sector Access Permission Checker

This block decides, one request at a time, whether a memory operation on one block of a four-block sector may go ahead. It looks at the current authentication state (which sector is open and whether key A or key B opened it) and at the three access-condition bytes read from that sector's trailer. Each block has a 3-bit permission code. Every bit of that code is stored twice in the trailer, once as is and once inverted. The checker first confirms that the two copies agree. It then turns the code of the addressed block into a key class: none, key A, key B or either key.

A controller pulses `auth_load` when an authentication succeeds and `halt` when the session ends. For each access it pulses `req_valid` with the operation, the target sector, the block index, the trailer field (used only for block 3) and the trailer's access bytes. One cycle later the checker answers with a grant bit and an integrity-error bit.

Top module: `sector_perm_checker`

## Requirements
- R1: No request is granted while no sector is authenticated. The block is unauthenticated after reset.
- R2: A request is granted only when the key class of the addressed item admits the key used to authenticate: class none (0) grants nothing, key A (1) grants only key A, key B (2) grants only key B, and either (3) grants both.
- R3: Access bytes are packed as acc_bits[7:0], [15:8] and [23:16]. For block i (0..3), C1 sits at bit 12+i and its inverse at bit i, C2 at bit 16+i with its inverse at bit 4+i, and C3 at bit 20+i with its inverse at bit 8+i. If any plain bit equals its inverted copy, every request is denied and rsp_integ_err is 1. Otherwise rsp_integ_err is 0.
- R4: For data blocks 0–2, the code value {C1,C2,C3} gives these classes for read / write / increment / (decrement, transfer, restore): 0: AB/AB/AB/AB; 1: AB/none/none/AB; 2: AB/none/none/none; 3: B/B/none/none; 4: AB/B/none/none; 5: B/none/none/none; 6: AB/B/B/AB; 7: none for all.
- R5: For block 3, the code gives these classes for key-A write, access-bits read, access-bits write, key-B read and key-B write: 0: A,A,none,A,A; 1: A,A,A,A,A; 2: none,A,none,A,none; 3: B,AB,B,none,B; 4: B,AB,none,none,B; 5: none,AB,B,none,none; 6 and 7: none,AB,none,none,none.
- R6: A read of key A (block 3, field 0) is never granted, whatever the code.
- R7: A request for a sector other than the one authenticated is denied.
- R8: A halt pulse clears the authenticated state from the next cycle on. When halt and auth_load arrive together, halt wins.
- R9: Each request strobe produces exactly one response. The response is valid in the cycle after the strobe and in no other cycle.
- R10: Operation codes are 0 read, 1 write, 2 increment, 3 decrement, 4 transfer, 5 restore. Fields are 0 key A, 1 access bits, 2 key B. Codes 6 and 7, field 3, and any operation other than read or write on block 3 are denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auth_load | input | 1 | Authentication succeeded; latch sector and key |
| auth_sector | input | SECTOR_W | Sector that was authenticated |
| auth_key_b | input | 1 | 1 if key B was used, 0 if key A |
| halt | input | 1 | End of session; clears authentication |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (R10) |
| req_sector | input | SECTOR_W | Target sector |
| req_blk | input | 2 | Block within sector, 3 = trailer |
| req_field | input | 2 | Trailer field (R10), ignored for data blocks |
| acc_bits | input | 24 | Access-condition bytes of the target sector (R3) |
| rsp_valid | output | 1 | Response valid |
| rsp_grant | output | 1 | Operation permitted |
| rsp_integ_err | output | 1 | Access bits failed the redundancy check |

## Verification
The bench builds the checker with SECTOR_W = 2. With this width there are four sectors, so a request to a sector other than the open one can be made from each side of the open sector. The table sweeps go through all eight codes, every operation code and every field, under both keys. The data-block codes are chosen differently from the target block's code, so a wrong block selection shows up as a wrong grant. The integrity test corrupts each of the 24 access bits in turn.

// File: rtl/sector_perm_pkg.sv
// Shared constants and types for the sector permission checker.
// Assumes four blocks per sector and 3-bit permission codes.
package sector_perm_pkg;
    localparam int NUM_BLK = 4;
    localparam int CODE_W  = 3;
    localparam int ACC_W   = 24;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_INC     = 3'd2,
        OP_DEC     = 3'd3,
        OP_XFER    = 3'd4,
        OP_RESTORE = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        FLD_KEYA = 2'd0,
        FLD_ACC  = 2'd1,
        FLD_KEYB = 2'd2
    } fld_e;

    // bit0: key A admitted, bit1: key B admitted
    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_A    = 2'd1,
        PERM_B    = 2'd2,
        PERM_AB   = 2'd3
    } perm_e;
endpackage

// File: rtl/acc_bits_decode.sv
// Unpacks the three trailer access bytes into one 3-bit code per block
// and confirms that every bit agrees with its inverted copy.
// Assumes the bit layout given in the brief (R3).
module acc_bits_decode
    import sector_perm_pkg::*;
(
    input  logic [ACC_W-1:0]          acc_bits,
    output logic [NUM_BLK*CODE_W-1:0] codes,
    output logic                      bits_ok
);
    logic [NUM_BLK-1:0] blk_ok;

    for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
        logic c1, c2, c3;
        // Pick the plain bits of block i and compare each with its inverse
        always_comb begin
            c1 = acc_bits[12+i];
            c2 = acc_bits[16+i];
            c3 = acc_bits[20+i];
            blk_ok[i] = (c1 ^ acc_bits[i]) & (c2 ^ acc_bits[4+i]) & (c3 ^ acc_bits[8+i]);
            codes[i*CODE_W +: CODE_W] = {c1, c2, c3};
        end
    end

    assign bits_ok = &blk_ok;
endmodule

// File: rtl/perm_lookup.sv
// Fixed combinational map from a block's 3-bit code, the operation and,
// for the trailer, the field, to the key class that may perform it.
// Assumes op/field encodings from sector_perm_pkg.
module perm_lookup
    import sector_perm_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [2:0]        op,
    input  logic              is_trailer,
    input  logic [1:0]        field,
    output perm_e             perm
);
    // Data block classes: read / write / increment / decrement-family
    function automatic perm_e data_perm(input logic [2:0] c, input logic [2:0] o);
        perm_e rd, wr, inc, dec;
        case (c)
            3'd0:    begin rd = PERM_AB; wr = PERM_AB;   inc = PERM_AB;   dec = PERM_AB;   end
            3'd1:    begin rd = PERM_AB; wr = PERM_NONE; inc = PERM_NONE; dec = PERM_AB;   end
            3'd2:    begin rd = PERM_AB; wr = PERM_NONE; inc = PERM_NONE; dec = PERM_NONE; end
            3'd3:    begin rd = PERM_B;  wr = PERM_B;    inc = PERM_NONE; dec = PERM_NONE; end
            3'd4:    begin rd = PERM_AB; wr = PERM_B;    inc = PERM_NONE; dec = PERM_NONE; end
            3'd5:    begin rd = PERM_B;  wr = PERM_NONE; inc = PERM_NONE; dec = PERM_NONE; end
            3'd6:    begin rd = PERM_AB; wr = PERM_B;    inc = PERM_B;    dec = PERM_AB;   end
            default: begin rd = PERM_NONE; wr = PERM_NONE; inc = PERM_NONE; dec = PERM_NONE; end
        endcase
        case (o)
            OP_READ:                     return rd;
            OP_WRITE:                    return wr;
            OP_INC:                      return inc;
            OP_DEC, OP_XFER, OP_RESTORE: return dec;
            default:                     return PERM_NONE;
        endcase
    endfunction

    // Trailer classes per field; key A is never readable
    function automatic perm_e trl_perm(input logic [2:0] c, input logic [2:0] o, input logic [1:0] f);
        perm_e ka_w, ac_r, ac_w, kb_r, kb_w;
        case (c)
            3'd0:    begin ka_w = PERM_A;    ac_r = PERM_A;  ac_w = PERM_NONE; kb_r = PERM_A;    kb_w = PERM_A;    end
            3'd1:    begin ka_w = PERM_A;    ac_r = PERM_A;  ac_w = PERM_A;    kb_r = PERM_A;    kb_w = PERM_A;    end
            3'd2:    begin ka_w = PERM_NONE; ac_r = PERM_A;  ac_w = PERM_NONE; kb_r = PERM_A;    kb_w = PERM_NONE; end
            3'd3:    begin ka_w = PERM_B;    ac_r = PERM_AB; ac_w = PERM_B;    kb_r = PERM_NONE; kb_w = PERM_B;    end
            3'd4:    begin ka_w = PERM_B;    ac_r = PERM_AB; ac_w = PERM_NONE; kb_r = PERM_NONE; kb_w = PERM_B;    end
            3'd5:    begin ka_w = PERM_NONE; ac_r = PERM_AB; ac_w = PERM_B;    kb_r = PERM_NONE; kb_w = PERM_NONE; end
            default: begin ka_w = PERM_NONE; ac_r = PERM_AB; ac_w = PERM_NONE; kb_r = PERM_NONE; kb_w = PERM_NONE; end
        endcase
        if (o == OP_READ) begin
            case (f)
                FLD_ACC:  return ac_r;
                FLD_KEYB: return kb_r;
                default:  return PERM_NONE;
            endcase
        end else if (o == OP_WRITE) begin
            case (f)
                FLD_KEYA: return ka_w;
                FLD_ACC:  return ac_w;
                FLD_KEYB: return kb_w;
                default:  return PERM_NONE;
            endcase
        end
        return PERM_NONE;
    endfunction

    // Select the table that applies to the addressed block
    always_comb begin
        perm = is_trailer ? trl_perm(code, op, field) : data_perm(code, op);
        assert_keya_unreadable_R6: assert (!(is_trailer && op == OP_READ && field == FLD_KEYA)
                                           || perm == PERM_NONE);
    end
endmodule

// File: rtl/auth_state.sv
// Holds which sector is authenticated and with which key.
// Assumes halt and reset both end the session; halt beats a same-cycle load.
module auth_state #(
    parameter int SECTOR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                auth_load,
    input  logic [SECTOR_W-1:0] auth_sector,
    input  logic                auth_key_b,
    input  logic                halt,
    output logic                auth_valid,
    output logic [SECTOR_W-1:0] auth_sec,
    output logic                auth_kb
);
    // Latch a new session or drop it on halt/reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auth_valid <= 1'b0;
            auth_sec   <= '0;
            auth_kb    <= 1'b0;
        end else if (halt) begin
            auth_valid <= 1'b0;
        end else if (auth_load) begin
            auth_valid <= 1'b1;
            auth_sec   <= auth_sector;
            auth_kb    <= auth_key_b;
        end
    end

    assert_halt_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !auth_valid);
    assert_load_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (auth_load && !halt) |=> (auth_valid && auth_sec == $past(auth_sector)));
endmodule

// File: rtl/sector_perm_checker.sv
// Top: combines authentication state, access-bit decode and permission
// lookup into a registered grant/integrity result one cycle after a request.
// Assumes acc_bits belong to req_sector and are stable with req_valid.
module sector_perm_checker
    import sector_perm_pkg::*;
#(
    parameter int SECTOR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                auth_load,
    input  logic [SECTOR_W-1:0] auth_sector,
    input  logic                auth_key_b,
    input  logic                halt,
    input  logic                req_valid,
    input  logic [2:0]          req_op,
    input  logic [SECTOR_W-1:0] req_sector,
    input  logic [1:0]          req_blk,
    input  logic [1:0]          req_field,
    input  logic [23:0]         acc_bits,
    output logic                rsp_valid,
    output logic                rsp_grant,
    output logic                rsp_integ_err
);
    localparam logic [1:0] TRAILER_IDX = 2'(NUM_BLK - 1);

    logic                      auth_valid;
    logic [SECTOR_W-1:0]       auth_sec;
    logic                      auth_kb;
    logic [NUM_BLK*CODE_W-1:0] codes;
    logic                      bits_ok;
    logic [CODE_W-1:0]         sel_code;
    perm_e                     perm;
    logic                      key_ok;
    logic                      grant_d;

    auth_state #(.SECTOR_W(SECTOR_W)) u_auth (
        .clk        (clk),
        .rst_n      (rst_n),
        .auth_load  (auth_load),
        .auth_sector(auth_sector),
        .auth_key_b (auth_key_b),
        .halt       (halt),
        .auth_valid (auth_valid),
        .auth_sec   (auth_sec),
        .auth_kb    (auth_kb)
    );

    acc_bits_decode u_dec (
        .acc_bits(acc_bits),
        .codes   (codes),
        .bits_ok (bits_ok)
    );

    perm_lookup u_lut (
        .code      (sel_code),
        .op        (req_op),
        .is_trailer(req_blk == TRAILER_IDX),
        .field     (req_field),
        .perm      (perm)
    );

    // Pick the addressed block's code and combine all grant conditions
    always_comb begin
        sel_code = codes[req_blk*CODE_W +: CODE_W];
        key_ok   = auth_kb ? perm[1] : perm[0];
        grant_d  = auth_valid && (auth_sec == req_sector) && bits_ok && key_ok;
    end

    // Register the verdict one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_grant     <= 1'b0;
            rsp_integ_err <= 1'b0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_grant     <= req_valid && grant_d;
            rsp_integ_err <= req_valid && !bits_ok;
        end
    end

    assert_no_grant_unauth_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !auth_valid) |=> !rsp_grant);
    assert_bad_bits_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !bits_ok) |=> (rsp_integ_err && !rsp_grant));
    assert_other_sector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && auth_sec != req_sector) |=> !rsp_grant);
    assert_one_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_idle_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_grant && !rsp_integ_err));
endmodule

// File: tb/sector_perm_checker_test.sv
`timescale 1ns/1ps
module sector_perm_checker_test;
    localparam int SW = 2;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          auth_load = 0;
    logic [SW-1:0] auth_sector = '0;
    logic          auth_key_b = 0;
    logic          halt = 0;
    logic          req_valid = 0;
    logic [2:0]    req_op = '0;
    logic [SW-1:0] req_sector = '0;
    logic [1:0]    req_blk = '0;
    logic [1:0]    req_field = '0;
    logic [23:0]   acc_bits = '0;
    logic          rsp_valid, rsp_grant, rsp_integ_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    sector_perm_checker #(.SECTOR_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .auth_load(auth_load), .auth_sector(auth_sector),
        .auth_key_b(auth_key_b), .halt(halt), .req_valid(req_valid), .req_op(req_op),
        .req_sector(req_sector), .req_blk(req_blk), .req_field(req_field),
        .acc_bits(acc_bits), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_integ_err(rsp_integ_err)
    );

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Pack four block codes per the R3 layout
    function automatic logic [23:0] mk_bits(input logic [2:0] c0, c1, c2, c3);
        logic [2:0] c [4];
        logic [23:0] b = '0;
        c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
        for (int i = 0; i < 4; i++) begin
            b[12+i] = c[i][2]; b[i]   = ~c[i][2];
            b[16+i] = c[i][1]; b[4+i] = ~c[i][1];
            b[20+i] = c[i][0]; b[8+i] = ~c[i][0];
        end
        return b;
    endfunction

    // R4 expected class: 0 none, 1 A, 2 B, 3 AB
    function automatic logic [1:0] exp_data(input int code, input int op);
        logic [1:0] rd, wr, inc, dec;
        case (code)
            0: {rd, wr, inc, dec} = {2'd3, 2'd3, 2'd3, 2'd3};
            1: {rd, wr, inc, dec} = {2'd3, 2'd0, 2'd0, 2'd3};
            2: {rd, wr, inc, dec} = {2'd3, 2'd0, 2'd0, 2'd0};
            3: {rd, wr, inc, dec} = {2'd2, 2'd2, 2'd0, 2'd0};
            4: {rd, wr, inc, dec} = {2'd3, 2'd2, 2'd0, 2'd0};
            5: {rd, wr, inc, dec} = {2'd2, 2'd0, 2'd0, 2'd0};
            6: {rd, wr, inc, dec} = {2'd3, 2'd2, 2'd2, 2'd3};
            default: {rd, wr, inc, dec} = 8'd0;
        endcase
        if (op == 0) return rd;
        if (op == 1) return wr;
        if (op == 2) return inc;
        if (op >= 3 && op <= 5) return dec;
        return 2'd0;
    endfunction

    // R5/R6/R10 expected trailer class
    function automatic logic [1:0] exp_trl(input int code, input int op, input int fld);
        logic [1:0] kaw, acr, acw, kbr, kbw;
        case (code)
            0: {kaw, acr, acw, kbr, kbw} = {2'd1, 2'd1, 2'd0, 2'd1, 2'd1};
            1: {kaw, acr, acw, kbr, kbw} = {2'd1, 2'd1, 2'd1, 2'd1, 2'd1};
            2: {kaw, acr, acw, kbr, kbw} = {2'd0, 2'd1, 2'd0, 2'd1, 2'd0};
            3: {kaw, acr, acw, kbr, kbw} = {2'd2, 2'd3, 2'd2, 2'd0, 2'd2};
            4: {kaw, acr, acw, kbr, kbw} = {2'd2, 2'd3, 2'd0, 2'd0, 2'd2};
            5: {kaw, acr, acw, kbr, kbw} = {2'd0, 2'd3, 2'd2, 2'd0, 2'd0};
            default: {kaw, acr, acw, kbr, kbw} = {2'd0, 2'd3, 2'd0, 2'd0, 2'd0};
        endcase
        if (op == 0) return (fld == 1) ? acr : (fld == 2) ? kbr : 2'd0;
        if (op == 1) return (fld == 0) ? kaw : (fld == 1) ? acw : (fld == 2) ? kbw : 2'd0;
        return 2'd0;
    endfunction

    task automatic do_auth(input logic [SW-1:0] sec, input logic kb);
        @(negedge clk);
        auth_load = 1; auth_sector = sec; auth_key_b = kb;
        @(negedge clk);
        auth_load = 0;
    endtask

    task automatic do_halt();
        @(negedge clk); halt = 1;
        @(negedge clk); halt = 0;
    endtask

    // One strobe; outputs sampled at the following falling edge
    task automatic do_req(input int op, input logic [SW-1:0] sec, input int blk,
                          input int fld, input logic [23:0] bits);
        @(negedge clk);
        req_valid = 1; req_op = 3'(op); req_sector = sec;
        req_blk = 2'(blk); req_field = 2'(fld); acc_bits = bits;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic t_reset();
        chk("R9", rsp_valid, 0, "rsp_valid after reset");
        chk("R1", rsp_grant, 0, "grant after reset");
        do_req(0, 0, 0, 0, mk_bits(0, 0, 0, 1));
        chk("R1", rsp_grant, 0, "unauthenticated read, open code");
        chk("R3", rsp_integ_err, 0, "well-formed bits report no error");
    endtask

    task automatic t_data_table();
        for (int kb = 0; kb < 2; kb++) begin
            do_auth(1, kb[0]);
            for (int code = 0; code < 8; code++) begin
                int blk = code % 3;
                logic [2:0] oth = 3'(~code);
                logic [2:0] c [4];
                for (int b = 0; b < 4; b++) c[b] = oth;
                c[blk] = 3'(code);
                for (int op = 0; op < 8; op++) begin
                    logic [1:0] cls = exp_data(code, op);
                    do_req(op, 1, blk, 3 - blk, mk_bits(c[0], c[1], c[2], c[3]));
                    chk(op > 5 ? "R10" : (kb == 0 ? "R4" : "R2"), rsp_grant, cls[kb],
                        $sformatf("data code=%0d op=%0d keyB=%0d", code, op, kb));
                    chk("R9", rsp_valid, 1, "response strobe");
                end
            end
        end
    endtask

    task automatic t_trailer_table();
        for (int kb = 0; kb < 2; kb++) begin
            do_auth(2, kb[0]);
            for (int code = 0; code < 8; code++) begin
                logic [2:0] oth = 3'(~code);
                for (int op = 0; op < 6; op++) begin
                    for (int fld = 0; fld < 4; fld++) begin
                        logic [1:0] cls = exp_trl(code, op, fld);
                        do_req(op, 2, 3, fld, mk_bits(oth, oth, oth, 3'(code)));
                        chk((op == 0 && fld == 0) ? "R6" : (op > 1 || fld == 3) ? "R10" : "R5",
                            rsp_grant, cls[kb],
                            $sformatf("trailer code=%0d op=%0d fld=%0d keyB=%0d", code, op, fld, kb));
                    end
                end
            end
        end
    endtask

    task automatic t_integrity();
        do_auth(0, 0);
        for (int bit_i = 0; bit_i < 24; bit_i++) begin
            logic [23:0] bad = mk_bits(0, 0, 0, 1);
            bad[bit_i] = ~bad[bit_i];
            do_req(0, 0, 0, 0, bad);
            chk("R3", rsp_integ_err, 1, $sformatf("error flag, bit %0d flipped", bit_i));
            chk("R3", rsp_grant, 0, $sformatf("grant, bit %0d flipped", bit_i));
        end
        do_req(0, 0, 0, 0, mk_bits(0, 0, 0, 1));
        chk("R3", rsp_grant, 1, "restored bits grant again");
        chk("R3", rsp_integ_err, 0, "restored bits clear error");
    endtask

    task automatic t_sector();
        do_auth(2, 1);
        for (int s = 0; s < 4; s++) begin
            do_req(0, 2'(s), 1, 0, mk_bits(0, 0, 0, 1));
            chk("R7", rsp_grant, s == 2, $sformatf("read sector %0d with sector 2 open", s));
        end
    endtask

    task automatic t_halt();
        do_auth(3, 0);
        do_req(0, 3, 0, 0, mk_bits(0, 0, 0, 1));
        chk("R8", rsp_grant, 1, "granted before halt");
        do_halt();
        do_req(0, 3, 0, 0, mk_bits(0, 0, 0, 1));
        chk("R8", rsp_grant, 0, "denied after halt");
        @(negedge clk);
        auth_load = 1; halt = 1; auth_sector = 3; auth_key_b = 0;
        @(negedge clk);
        auth_load = 0; halt = 0;
        do_req(0, 3, 0, 0, mk_bits(0, 0, 0, 1));
        chk("R8", rsp_grant, 0, "halt beats same-cycle load");
        do_auth(3, 0);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        do_req(0, 3, 0, 0, mk_bits(0, 0, 0, 1));
        chk("R1", rsp_grant, 0, "denied after reset clears session");
    endtask

    task automatic t_latency();
        do_auth(1, 0);
        do_req(0, 1, 0, 0, mk_bits(0, 0, 0, 1));
        chk("R9", rsp_valid, 1, "valid one cycle after strobe");
        @(negedge clk);
        chk("R9", rsp_valid, 0, "valid drops without strobe");
        chk("R9", rsp_grant, 0, "grant drops without strobe");
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_data_table();
        t_trailer_table();
        t_integrity();
        t_sector();
        t_halt();
        t_latency();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule